// File: doc/BRIEF.md
# Synchronous Serial Port with Transmit and Receive FIFOs

This peripheral sits between a processor's simple register access and a synchronous serial line. Bytes the processor writes are queued in a four-entry transmit FIFO. A shift engine takes each byte from the queue and drives it out serially. A receive engine collects serial bits into bytes and queues them in a four-entry receive FIFO, which the processor reads back.

Everything runs on one clock, `clk`. The serial clock is produced by dividing `clk` by two, so each bit lasts two `clk` cycles. A frame pulse marks the first bit of each byte. An active-low enable shows when the transmit line carries data. Bytes leave back-to-back for as long as the transmit queue holds data.

The processor side has no handshake; a full queue is the only back-pressure. While a queue holds four bytes, its full interrupt is high. A byte offered to a full queue is dropped: a write when the transmit queue is full, or a completed serial byte when the receive queue is full. Software must watch the interrupts to avoid losing data. The clear input is synchronous.

Top module: `sync_serial_port`

## Requirements
- R1: While `clr_n` is low at a rising clock edge, all state clears at that edge. After the edge: `rdata`=0, `oe_n`=1, `tx_data`=0, `frame_out`=0, `ser_clk_out`=0, and both interrupts are 0. Both queues become empty.
- R2: `ser_clk_out` inverts on every clock edge while the block is out of clear, so one serial bit spans two clock cycles.
- R3: A cycle with `sel`=1 and `wr`=1 pushes `wdata` into the transmit queue, which holds 4 bytes. `tx_full_irq` is high exactly while the queue holds 4 bytes.
- R4: A write offered while the transmit queue is full is dropped and never transmitted.
- R5: Frame format:
  - Each byte is sent as 8 bits, most significant bit first.
  - A new bit is driven at each edge where `ser_clk_out` goes from 0 to 1, and it is held for two cycles.
  - `frame_out` is high for the first bit only.
  - `oe_n` is 0 during all 8 bits and 1 when no byte is being sent.
  - When `ser_clk_out` rises and the engine is idle or finishing a byte, it takes the next byte only if the queue held one before that edge.
- R6: If the transmit queue is not empty when the last bit of a byte ends, the next byte starts at that same point. There are no idle bits and `oe_n` does not go high between the two bytes.
- R7: Receive timing:
  - The receiver samples `rx_data` and `frame_in` at each clock edge where `ser_clk_in` is 1 and was 0 at the previous edge.
  - A sample with `frame_in`=1 starts a new byte; this restarts any byte in progress.
  - The eighth sampled bit completes the byte, which is pushed into the receive queue.
- R8: A cycle with `sel`=1 and `wr`=0 loads the head of the receive queue into `rdata` at that edge and removes it. `rdata` holds its value between reads.
- R9: A read of an empty receive queue sets `rdata` to 0 and leaves the queue unchanged.
- R10: `rx_full_irq` is high exactly while the receive queue holds 4 bytes. A byte completed while the queue is full is dropped.
- R11: With the serial outputs looped back to the serial inputs, every byte that is written and accepted is read back intact and in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| clr_n | input | 1 | Synchronous clear, active low |
| sel | input | 1 | Access select |
| wr | input | 1 | 1 = write to transmit queue, 0 = read from receive queue |
| wdata | input | 8 | Byte to transmit |
| rdata | output | 8 | Last byte read from the receive queue |
| ser_clk_in | input | 1 | Serial clock for reception |
| frame_in | input | 1 | Frame start for reception |
| rx_data | input | 1 | Serial receive data |
| oe_n | output | 1 | Transmit line valid, active low |
| tx_data | output | 1 | Serial transmit data |
| ser_clk_out | output | 1 | Serial clock, half the block clock rate |
| frame_out | output | 1 | Frame start for transmission |
| tx_full_irq | output | 1 | Transmit queue full |
| rx_full_irq | output | 1 | Receive queue full |

## Verification
Faults in the transmit engine reach the serial pins quickly:
- A wrong bit index or shift register shows on `tx_data` within one bit, which is two cycles.
- A bad load decision shows on `frame_out` or `oe_n` at the next rising edge of the serial clock.

Faults in the queues take longer to show. A wrong pointer or count reaches the ports only when the next byte is read or when a full interrupt changes. In loopback, a receive fault shows about sixteen cycles after the frame pulse, when the byte is read back. A cycle-level reference model is compared against every output on every clock, so the first difference is reported in the cycle it appears.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  typedef enum logic {
    TX_IDLE  = 1'b0,
    TX_SHIFT = 1'b1
  } tx_state_e;
endpackage

// File: rtl/ssp_fifo.sv
module ssp_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] count;
  logic          push_ok, pop_ok;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign head    = mem[rd_ptr];

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!clr_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= nxt(wr_ptr);
      if (pop_ok)  rd_ptr <= nxt(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!clr_n)
    (full && push && !pop) |=> (full && $stable(wr_ptr))); // R4
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!clr_n)
    (empty && pop && !push) |=> (empty && $stable(rd_ptr))); // R9
endmodule

// File: rtl/ssp_tx.sv
module ssp_tx
  import ssp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         fifo_empty,
  input  logic [W-1:0] fifo_head,
  output logic         fifo_pop,
  output logic         ser_clk,
  output logic         tx_bit,
  output logic         frame,
  output logic         oe_n
);
  localparam int BW = $clog2(W);

  tx_state_e     state;
  logic [BW-1:0] bit_idx;
  logic [W-1:0]  shreg;
  logic          tick, last;

  assign tick     = !ser_clk;
  assign last     = (state == TX_SHIFT) && (bit_idx == BW'(W - 1));
  assign fifo_pop = tick && ((state == TX_IDLE) || last) && !fifo_empty;

  always_ff @(posedge clk) begin
    if (!clr_n) begin
      ser_clk <= 1'b0;
      state   <= TX_IDLE;
      bit_idx <= '0;
      shreg   <= '0;
      tx_bit  <= 1'b0;
      frame   <= 1'b0;
      oe_n    <= 1'b1;
    end else begin
      ser_clk <= !ser_clk;
      if (tick) begin
        if ((state == TX_SHIFT) && !last) begin
          tx_bit  <= shreg[W-1];
          shreg   <= {shreg[W-2:0], 1'b0};
          bit_idx <= bit_idx + 1'b1;
          frame   <= 1'b0;
        end else if (!fifo_empty) begin
          tx_bit  <= fifo_head[W-1];
          shreg   <= {fifo_head[W-2:0], 1'b0};
          bit_idx <= '0;
          frame   <= 1'b1;
          oe_n    <= 1'b0;
          state   <= TX_SHIFT;
        end else begin
          state   <= TX_IDLE;
          tx_bit  <= 1'b0;
          frame   <= 1'b0;
          oe_n    <= 1'b1;
        end
      end
    end
  end

  AST_SCLK_TOGGLE: assert property (@(posedge clk) disable iff (!clr_n)
    1'b1 |=> (ser_clk != $past(ser_clk))); // R2
  AST_FRAME_IN_OE: assert property (@(posedge clk) disable iff (!clr_n)
    frame |-> !oe_n); // R5
  AST_FRAME_WIDTH: assert property (@(posedge clk) disable iff (!clr_n)
    (frame && $past(frame)) |=> !frame); // R5
  AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!clr_n)
    (tick && last && !fifo_empty) |=> (frame && !oe_n)); // R6
endmodule

// File: rtl/ssp_rx.sv
module ssp_rx #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         ser_clk_in,
  input  logic         frame_in,
  input  logic         rx_bit,
  output logic         push,
  output logic [W-1:0] word
);
  localparam int BW = $clog2(W);

  logic          clk_d, active, sample;
  logic [BW-1:0] cnt;
  logic [W-1:0]  sh;

  assign sample = ser_clk_in && !clk_d;
  assign push   = sample && !frame_in && active && (cnt == BW'(W - 1));
  assign word   = {sh[W-2:0], rx_bit};

  always_ff @(posedge clk) begin
    if (!clr_n) begin
      clk_d  <= 1'b0;
      active <= 1'b0;
      cnt    <= '0;
      sh     <= '0;
    end else begin
      clk_d <= ser_clk_in;
      if (sample) begin
        if (frame_in) begin
          sh     <= {sh[W-2:0], rx_bit};
          cnt    <= BW'(1);
          active <= 1'b1;
        end else if (active) begin
          sh <= {sh[W-2:0], rx_bit};
          if (cnt == BW'(W - 1)) active <= 1'b0;
          else                   cnt    <= cnt + 1'b1;
        end
      end
    end
  end

  AST_RX_PUSH_SPACING: assert property (@(posedge clk) disable iff (!clr_n)
    push |=> !push); // R7
endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         sel,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  input  logic         ser_clk_in,
  input  logic         frame_in,
  input  logic         rx_data,
  output logic         oe_n,
  output logic         tx_data,
  output logic         ser_clk_out,
  output logic         frame_out,
  output logic         tx_full_irq,
  output logic         rx_full_irq
);
  logic         tx_pop, tx_empty;
  logic [W-1:0] tx_head;
  logic         rx_push, rx_empty, rd_req;
  logic [W-1:0] rx_word, rx_head;

  assign rd_req = sel && !wr;

  ssp_fifo #(.W(W), .DEPTH(DEPTH)) u_tx_fifo (
    .clk(clk), .clr_n(clr_n), .push(sel && wr), .push_data(wdata),
    .pop(tx_pop), .head(tx_head), .empty(tx_empty), .full(tx_full_irq)
  );

  ssp_tx #(.W(W)) u_tx (
    .clk(clk), .clr_n(clr_n), .fifo_empty(tx_empty), .fifo_head(tx_head),
    .fifo_pop(tx_pop), .ser_clk(ser_clk_out), .tx_bit(tx_data),
    .frame(frame_out), .oe_n(oe_n)
  );

  ssp_rx #(.W(W)) u_rx (
    .clk(clk), .clr_n(clr_n), .ser_clk_in(ser_clk_in), .frame_in(frame_in),
    .rx_bit(rx_data), .push(rx_push), .word(rx_word)
  );

  ssp_fifo #(.W(W), .DEPTH(DEPTH)) u_rx_fifo (
    .clk(clk), .clr_n(clr_n), .push(rx_push), .push_data(rx_word),
    .pop(rd_req), .head(rx_head), .empty(rx_empty), .full(rx_full_irq)
  );

  always_ff @(posedge clk) begin
    if (!clr_n)      rdata <= '0;
    else if (rd_req) rdata <= rx_empty ? '0 : rx_head;
  end

  AST_READ_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!clr_n)
    (rd_req && rx_empty) |=> (rdata == '0)); // R9
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!clr_n)
    !rd_req |=> $stable(rdata)); // R8
endmodule

// File: tb/sync_serial_port_tb.sv
module sync_serial_port_tb;
  logic       clk = 1'b0;
  logic       clr_n = 1'b0;
  logic       sel = 1'b0, wr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       oe_n, tx_data, ser_clk_out, frame_out, tx_full_irq, rx_full_irq;

  int checks = 0, fails = 0;
  bit done = 0, running = 0;

  always #5 clk = ~clk;

  sync_serial_port u_dut (
    .clk(clk), .clr_n(clr_n), .sel(sel), .wr(wr), .wdata(wdata), .rdata(rdata),
    .ser_clk_in(ser_clk_out), .frame_in(frame_out), .rx_data(tx_data),
    .oe_n(oe_n), .tx_data(tx_data), .ser_clk_out(ser_clk_out),
    .frame_out(frame_out), .tx_full_irq(tx_full_irq), .rx_full_irq(rx_full_irq)
  );

  // behavioural reference model
  bit [7:0] m_txq[$], m_rxq[$];
  bit       m_sclk, m_prev, m_txd, m_frm, m_oen, m_busy, m_act;
  int       m_bit, m_cnt;
  bit [7:0] m_sh, m_acc, m_rd;

  always @(posedge clk) begin
    bit o_sclk, o_txd, o_frm, rx_push;
    int tx_sz, rx_sz;
    bit [7:0] rxw;
    if (!clr_n) begin
      m_txq.delete(); m_rxq.delete();
      m_sclk = 0; m_prev = 0; m_txd = 0; m_frm = 0; m_oen = 1; m_busy = 0;
      m_act = 0; m_bit = 0; m_cnt = 0; m_sh = 0; m_acc = 0; m_rd = 0;
    end else begin
      o_sclk = m_sclk; o_txd = m_txd; o_frm = m_frm;
      tx_sz = m_txq.size(); rx_sz = m_rxq.size();
      rx_push = 0; rxw = 0;
      if (o_sclk && !m_prev) begin
        if (o_frm) begin
          m_acc = {7'b0, o_txd}; m_cnt = 1; m_act = 1;
        end else if (m_act) begin
          m_acc = {m_acc[6:0], o_txd}; m_cnt++;
          if (m_cnt == 8) begin rxw = m_acc; rx_push = 1; m_act = 0; end
        end
      end
      m_prev = o_sclk;
      if (sel && !wr) begin
        if (rx_sz == 0) m_rd = 0;
        else m_rd = m_rxq.pop_front();
      end
      if (rx_push && rx_sz < 4) m_rxq.push_back(rxw);
      if (!o_sclk) begin
        if (m_busy && m_bit < 7) begin
          m_bit++; m_txd = m_sh[7 - m_bit]; m_frm = 0;
        end else if (tx_sz > 0) begin
          m_sh = m_txq.pop_front(); m_bit = 0; m_txd = m_sh[7];
          m_frm = 1; m_oen = 0; m_busy = 1;
        end else begin
          m_busy = 0; m_txd = 0; m_frm = 0; m_oen = 1;
        end
      end
      if (sel && wr && tx_sz < 4) m_txq.push_back(wdata);
      m_sclk = !o_sclk;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (running) begin
      chk("R2 ser_clk_out", ser_clk_out, m_sclk);
      chk("R5 tx_data", tx_data, m_txd);
      chk("R5 frame_out", frame_out, m_frm);
      chk("R5 oe_n", oe_n, m_oen);
      chk("R3 tx_full_irq", tx_full_irq, (m_txq.size() == 4));
      chk("R10 rx_full_irq", rx_full_irq, (m_rxq.size() == 4));
      chk("R8 rdata", rdata, m_rd);
    end
  end

  // port monitors for frame shape and back-to-back streaming
  int frm_cycles = 0, oe_low_cycles = 0, oe_rises = 0;
  bit oe_prev = 1;
  always @(negedge clk) begin
    if (frame_out) frm_cycles++;
    if (!oe_n) oe_low_cycles++;
    if (oe_n && !oe_prev) oe_rises++;
    oe_prev = oe_n;
  end

  task automatic clear_mon();
    frm_cycles = 0; oe_low_cycles = 0; oe_rises = 0;
  endtask

  task automatic do_write(input bit [7:0] b);
    @(negedge clk); sel = 1; wr = 1; wdata = b;
    @(negedge clk); sel = 0; wr = 0;
  endtask

  task automatic do_read(output bit [7:0] b);
    @(negedge clk); sel = 1; wr = 0;
    @(negedge clk); sel = 0; b = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_idle_outputs(input string tag);
    chk({tag, " rdata"}, rdata, 0);
    chk({tag, " oe_n"}, oe_n, 1);
    chk({tag, " tx_data"}, tx_data, 0);
    chk({tag, " frame_out"}, frame_out, 0);
    chk({tag, " ser_clk_out"}, ser_clk_out, 0);
    chk({tag, " tx_full_irq"}, tx_full_irq, 0);
    chk({tag, " rx_full_irq"}, rx_full_irq, 0);
  endtask

  initial begin
    bit [7:0] r;
    repeat (3) @(negedge clk);
    chk_idle_outputs("R1 reset");
    running = 1;
    clr_n = 1;

    // single byte, frame shape and loopback
    idle(2); clear_mon();
    do_write(8'hA5);
    idle(40);
    chk("R5 frame cycles", frm_cycles, 2);
    chk("R5 oe_n low cycles", oe_low_cycles, 16);
    do_read(r); chk("R7 loopback byte", r, 8'hA5);
    do_read(r); chk("R9 empty read", r, 0);

    // fill transmit queue, overflow both queues
    clear_mon();
    do_write(8'h3C);
    idle(3);
    do_write(8'h11); do_write(8'h22); do_write(8'h33); do_write(8'h44);
    chk("R3 tx queue full", tx_full_irq, 1);
    do_write(8'h55);
    idle(110);
    chk("R4 frames sent", frm_cycles, 10);
    chk("R6 oe_n rises", oe_rises, 1);
    chk("R6 oe_n low cycles", oe_low_cycles, 80);
    chk("R10 rx queue full", rx_full_irq, 1);
    do_read(r); chk("R11 order 0", r, 8'h3C);
    chk("R10 rx not full after read", rx_full_irq, 0);
    do_read(r); chk("R11 order 1", r, 8'h11);
    do_read(r); chk("R11 order 2", r, 8'h22);
    do_read(r); chk("R11 order 3", r, 8'h33);
    do_read(r); chk("R10 dropped byte", r, 0);

    // synchronous clear mid-frame
    do_write(8'h0F);
    idle(6);
    clr_n = 0;
    @(negedge clk);
    chk_idle_outputs("R1 mid-frame clear");
    clr_n = 1;
    idle(2);
    do_write(8'h81);
    idle(40);
    do_read(r); chk("R11 after clear", r, 8'h81);
    do_read(r); chk("R9 empty after clear", r, 0);

    idle(4);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule